// File: doc/BRIEF.md
# Logic IC Test Vector Executor

This block runs one test vector against a logic device that has a fixed number of pins. Each pin carries a 4-bit symbol. The symbol tells the block what to do with that pin: tie it to ground or supply, drive it at a level, drive it with a timed pulse or edge, sample it against an expected level, check that it floats, or leave it alone. A single shared timer takes every vector through three drive sub-phases and then two sample sub-phases. Pulse and edge pins change level between the drive sub-phases, while every static pin keeps its level. The device therefore sees the stimulus change in the middle of the vector. At the end of the vector the block reports a fail bit for each pin and one pass flag for the whole vector.

The control pins are plain and there is no back-pressure. A `start` pulse is taken only while `busy` is low. When it is taken, the block latches the vector and the phase length. `done` pulses for one cycle when the results are ready. The results hold until the next `done`. A host may raise `start` again in the same cycle as `done`.

Top module: `tvx_exec`

## Requirements
- R1: A `start` is taken only while `busy` is low. A `start` raised while `busy` is high has no effect on the running vector. `busy` then stays high for exactly 5*(phase_len+1) cycles. `done` is high for exactly one cycle, the cycle after `busy` falls.
- R2: Codes 3 (low) and 4 (high) set `drv_en`, and drive 0 or 1 respectively, through all five sub-phases. While the block is idle, all drive, supply and pull outputs are 0.
- R3: Code 5 drives 0, 1, 0 in sub-phases D0, D1, D2. Code 6 drives 1, 0, 1. Both hold the D2 level during the sample sub-phases.
- R4: Code 7 drives 0 in D0 and 1 from D1 onward. Code 8 drives 1 in D0 and 0 from D1 onward.
- R5: Codes 0 (ground) and 1 (supply) set `sup_en` while busy, with `sup_val` equal to the code. These pins never have `drv_en` set.
- R6: Codes 2 and 9 to 15 are never driven. Only code 11 (float) pins enable pulls: `pull_up` during sample sub-phase A and `pull_dn` during sample sub-phase B.
- R7: Code 9 (expect low) fails if the pin reads 1 in the last cycle of sample A. Code 10 (expect high) fails if it reads 0 there.
- R8: Code 11 passes only if the pin reads 1 in the last cycle of sample A and 0 in the last cycle of sample B.
- R9: Codes 0 to 8 never fail. Codes 12 to 15 are invalid and always fail.
- R10: `fail_mask` and `pass` change only on the edge that raises `done`. `pass` is 1 exactly when `fail_mask` is all zero. After reset both are 0.
- R11: Each sub-phase lasts phase_len+1 cycles. `phase_len` is latched when `start` is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a vector (taken when idle) |
| vec | input | NPIN*4 | Per-pin symbol codes; pin i at bits 4i+3:4i |
| phase_len | input | LENW | Sub-phase length minus one |
| pin_in | input | NPIN | Levels read back from the device pins |
| busy | output | 1 | Vector in progress |
| done | output | 1 | One-cycle result strobe |
| drv_en | output | NPIN | Drive enable per pin |
| drv_val | output | NPIN | Drive level per pin |
| sup_en | output | NPIN | Pin tied to a rail |
| sup_val | output | NPIN | Rail select: 0 ground, 1 supply |
| pull_up | output | NPIN | Weak pull-up enable |
| pull_dn | output | NPIN | Weak pull-down enable |
| fail_mask | output | NPIN | Per-pin failure result |
| pass | output | 1 | Whole-vector pass |

## Verification
Call the edge that takes `start` edge 0. The drive, supply and pull outputs for sub-phase k, cycle c are valid in cycle k*(phase_len+1)+c+1 after edge 0. They come from registered state through logic only, so there is no extra delay. `done`, `fail_mask` and `pass` appear one cycle after the last sample cycle, which is cycle 5*(phase_len+1)+1 after edge 0. The bench walks every cycle of each vector at the falling edge. It compares the outputs against levels it computes itself for the sub-phase that cycle belongs to, then checks the results on the `done` cycle and checks that they still hold one cycle later.

// File: rtl/tvx_pkg.sv
package tvx_pkg;
  localparam int SYMW = 4;

  localparam logic [SYMW-1:0] SYM_GND  = 4'd0;
  localparam logic [SYMW-1:0] SYM_VCC  = 4'd1;
  localparam logic [SYMW-1:0] SYM_IGN  = 4'd2;
  localparam logic [SYMW-1:0] SYM_LO   = 4'd3;
  localparam logic [SYMW-1:0] SYM_HI   = 4'd4;
  localparam logic [SYMW-1:0] SYM_PPUL = 4'd5;
  localparam logic [SYMW-1:0] SYM_NPUL = 4'd6;
  localparam logic [SYMW-1:0] SYM_RISE = 4'd7;
  localparam logic [SYMW-1:0] SYM_FALL = 4'd8;
  localparam logic [SYMW-1:0] SYM_XLO  = 4'd9;
  localparam logic [SYMW-1:0] SYM_XHI  = 4'd10;
  localparam logic [SYMW-1:0] SYM_XZ   = 4'd11;

  typedef enum logic [2:0] {
    PH_IDLE, PH_D0, PH_D1, PH_D2, PH_SA, PH_SB
  } phase_e;

  // Drive levels for sub-phases {D2, D1, D0}
  function automatic logic [2:0] sym_pattern(input logic [SYMW-1:0] c);
    unique case (c)
      SYM_HI:   return 3'b111;
      SYM_PPUL: return 3'b010;
      SYM_NPUL: return 3'b101;
      SYM_RISE: return 3'b110;
      SYM_FALL: return 3'b001;
      default:  return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/tvx_seq.sv
module tvx_seq
  import tvx_pkg::*;
#(
  parameter int LENW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [LENW-1:0] len,
  output phase_e          phase,
  output logic            busy,
  output logic            accept,
  output logic            cap_a,
  output logic            fin,
  output logic            done
);
  logic [LENW-1:0] cnt;
  logic [LENW-1:0] len_q;
  logic            last;

  assign busy   = (phase != PH_IDLE);
  assign accept = start && !busy;
  assign last   = (cnt == len_q);
  assign cap_a  = (phase == PH_SA) && last;
  assign fin    = (phase == PH_SB) && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      len_q <= '0;
      done  <= 1'b0;
    end else begin
      done <= fin;
      if (accept) begin
        phase <= PH_D0;
        cnt   <= '0;
        len_q <= len;
      end else if (busy) begin
        if (last) begin
          cnt <= '0;
          unique case (phase)
            PH_D0:   phase <= PH_D1;
            PH_D1:   phase <= PH_D2;
            PH_D2:   phase <= PH_SA;
            PH_SA:   phase <= PH_SB;
            default: phase <= PH_IDLE;
          endcase
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt <= len_q));
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r1_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r1_accept_d0: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_D0) && (cnt == '0));
endmodule

// File: rtl/tvx_drive.sv
module tvx_drive
  import tvx_pkg::*;
(
  input  phase_e          phase,
  input  logic [SYMW-1:0] code,
  output logic            drv_en,
  output logic            drv_val,
  output logic            sup_en,
  output logic            sup_val,
  output logic            pull_up,
  output logic            pull_dn
);
  logic       active;
  logic       is_drv;
  logic [2:0] pat;
  logic [1:0] step;

  assign active = (phase != PH_IDLE);
  assign is_drv = (code >= SYM_LO) && (code <= SYM_FALL);
  assign pat    = sym_pattern(code);

  always_comb begin
    unique case (phase)
      PH_D0:   step = 2'd0;
      PH_D1:   step = 2'd1;
      default: step = 2'd2;
    endcase
  end

  assign drv_en  = active && is_drv;
  assign drv_val = drv_en && pat[step];
  assign sup_en  = active && (code <= SYM_VCC);
  assign sup_val = sup_en && code[0];
  assign pull_up = (phase == PH_SA) && (code == SYM_XZ);
  assign pull_dn = (phase == PH_SB) && (code == SYM_XZ);
endmodule

// File: rtl/tvx_check.sv
module tvx_check
  import tvx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SYMW-1:0] code,
  input  logic            pin_in,
  input  logic            cap_a,
  output logic            fail_nx
);
  logic rd_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_a <= 1'b0;
    else if (cap_a) rd_a <= pin_in;
  end

  // Evaluated while in the last cycle of sample B
  always_comb begin
    if (code <= SYM_FALL)     fail_nx = 1'b0;
    else if (code == SYM_XLO) fail_nx = rd_a;
    else if (code == SYM_XHI) fail_nx = !rd_a;
    else if (code == SYM_XZ)  fail_nx = !(rd_a && !pin_in);
    else                      fail_nx = 1'b1;
  end
endmodule

// File: rtl/tvx_exec.sv
module tvx_exec
  import tvx_pkg::*;
#(
  parameter int NPIN = 8,
  parameter int LENW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NPIN*SYMW-1:0] vec,
  input  logic [LENW-1:0]      phase_len,
  input  logic [NPIN-1:0]      pin_in,
  output logic                 busy,
  output logic                 done,
  output logic [NPIN-1:0]      drv_en,
  output logic [NPIN-1:0]      drv_val,
  output logic [NPIN-1:0]      sup_en,
  output logic [NPIN-1:0]      sup_val,
  output logic [NPIN-1:0]      pull_up,
  output logic [NPIN-1:0]      pull_dn,
  output logic [NPIN-1:0]      fail_mask,
  output logic                 pass
);
  localparam int VW = NPIN * SYMW;

  phase_e          phase;
  logic            accept, cap_a, fin;
  logic [VW-1:0]   vec_q;
  logic [NPIN-1:0] fail_nx;

  tvx_seq #(.LENW(LENW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .len(phase_len),
    .phase(phase), .busy(busy), .accept(accept), .cap_a(cap_a),
    .fin(fin), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vec_q <= '0;
    else if (accept) vec_q <= vec;
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic [SYMW-1:0] code;
    assign code = vec_q[g*SYMW +: SYMW];

    tvx_drive u_drv (
      .phase(phase), .code(code),
      .drv_en(drv_en[g]), .drv_val(drv_val[g]),
      .sup_en(sup_en[g]), .sup_val(sup_val[g]),
      .pull_up(pull_up[g]), .pull_dn(pull_dn[g])
    );

    tvx_check u_chk (
      .clk(clk), .rst_n(rst_n), .code(code), .pin_in(pin_in[g]),
      .cap_a(cap_a), .fail_nx(fail_nx[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fail_mask <= '0;
      pass      <= 1'b0;
    end else if (fin) begin
      fail_mask <= fail_nx;
      pass      <= (fail_nx == '0);
    end
  end

  a_r6_no_clash: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en & sup_en) == '0);
  a_r6_pull_excl: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up & pull_dn) == '0);
  a_r2_idle_release: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (drv_en == '0) && (sup_en == '0) && (pull_up == '0) && (pull_dn == '0));
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fin |=> $stable(fail_mask) && $stable(pass));
  a_r10_pass_agree: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass == (fail_mask == '0)));
endmodule

// File: tb/tvx_exec_test.sv
module tvx_exec_test;
  localparam int NPIN = 8;
  localparam int LENW = 8;

  logic              clk = 1'b0;
  logic              rst_n, start;
  logic [NPIN*4-1:0] vec;
  logic [LENW-1:0]   phase_len;
  logic [NPIN-1:0]   pin_in;
  logic              busy, done, pass;
  logic [NPIN-1:0]   drv_en, drv_val, sup_en, sup_val, pull_up, pull_dn, fail_mask;

  int         checks = 0;
  int         errors = 0;
  logic [3:0] cq [NPIN];
  logic [1:0] md [NPIN];  // 0 floating, 1 stuck low, 2 stuck high

  always #5 clk = ~clk;

  tvx_exec #(.NPIN(NPIN), .LENW(LENW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .vec(vec), .phase_len(phase_len),
    .pin_in(pin_in), .busy(busy), .done(done), .drv_en(drv_en), .drv_val(drv_val),
    .sup_en(sup_en), .sup_val(sup_val), .pull_up(pull_up), .pull_dn(pull_dn),
    .fail_mask(fail_mask), .pass(pass)
  );

  always_comb begin
    for (int i = 0; i < NPIN; i++)
      pin_in[i] = (md[i] == 2'd1) ? 1'b0 : (md[i] == 2'd2) ? 1'b1 : pull_up[i];
  end

  function automatic logic is_drv(input logic [3:0] c);
    return (c >= 4'd3) && (c <= 4'd8);
  endfunction

  function automatic logic lvl(input logic [3:0] c, input int st);
    case (c)
      4'd4:    return 1'b1;
      4'd5:    return st == 1;
      4'd6:    return st != 1;
      4'd7:    return st != 0;
      4'd8:    return st == 0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic exp_fail(input logic [3:0] c, input logic [1:0] m);
    logic ra, rb;
    ra = (m == 2'd2) ? 1'b1 : (m == 2'd1) ? 1'b0 : (c == 4'd11);
    rb = (m == 2'd2);
    if (c <= 4'd8)  return 1'b0;
    if (c == 4'd9)  return ra;
    if (c == 4'd10) return !ra;
    if (c == 4'd11) return !(ra && !rb);
    return 1'b1;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic run(input logic [NPIN*4-1:0] v, input int len, input int stray);
    logic [NPIN-1:0] ed, dv, se, sv, pu, pd, ef, held;
    vec = v;
    phase_len = LENW'(len);
    for (int i = 0; i < NPIN; i++) cq[i] = v[i*4 +: 4];
    start = 1'b1;
    @(negedge clk);
    for (int ph = 0; ph < 5; ph++) begin
      for (int c = 0; c <= len; c++) begin
        for (int i = 0; i < NPIN; i++) begin
          ed[i] = is_drv(cq[i]);
          dv[i] = ed[i] && lvl(cq[i], (ph < 2) ? ph : 2);
          se[i] = cq[i] <= 4'd1;
          sv[i] = cq[i] == 4'd1;
          pu[i] = (ph == 3) && (cq[i] == 4'd11);
          pd[i] = (ph == 4) && (cq[i] == 4'd11);
        end
        chk(busy === 1'b1, "R1 R11 busy", 32'(busy), 1);
        chk(done === 1'b0, "R1 done early", 32'(done), 0);
        chk(drv_en === ed && drv_val === dv, "R2 R3 R4 drive",
            {drv_en, drv_val}, {ed, dv});
        chk(sup_en === se && sup_val === sv, "R5 supply", {sup_en, sup_val}, {se, sv});
        chk(pull_up === pu && pull_dn === pd, "R6 pulls", {pull_up, pull_dn}, {pu, pd});
        if (ph * (len + 1) + c == stray) begin
          start = 1'b1;  // R1: must be ignored while busy
          vec = {$urandom, $urandom};
          phase_len = LENW'($urandom % 7);
        end else begin
          start = 1'b0;
        end
        @(negedge clk);
      end
    end
    start = 1'b0;
    for (int i = 0; i < NPIN; i++) ef[i] = exp_fail(cq[i], md[i]);
    chk(done === 1'b1, "R1 done", 32'(done), 1);
    chk(busy === 1'b0, "R11 busy end", 32'(busy), 0);
    chk(fail_mask === ef, "R7 R8 R9 fail_mask", 32'(fail_mask), 32'(ef));
    chk(pass === (ef == '0), "R10 pass", 32'(pass), 32'(ef == '0));
    held = fail_mask;
    @(negedge clk);
    chk(done === 1'b0, "R1 done one cycle", 32'(done), 0);
    chk(fail_mask === held, "R10 hold", 32'(fail_mask), 32'(held));
    chk(drv_en == '0 && sup_en == '0 && pull_up == '0 && pull_dn == '0,
        "R2 R6 idle release", {drv_en, sup_en, pull_up, pull_dn}, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NPIN*4-1:0] v;
    void'($urandom(32'd4242));
    rst_n = 1'b0; start = 1'b0; vec = '0; phase_len = '0;
    for (int i = 0; i < NPIN; i++) md[i] = 2'd0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset ctl", {busy, done}, 0);
    chk(fail_mask === '0 && pass === 1'b0, "R10 reset result", {fail_mask, pass}, 0);
    chk(drv_en === '0 && sup_en === '0, "R2 reset release", {drv_en, sup_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Directed: every code 0..15, short and longer phases
    for (int i = 0; i < NPIN; i++) v[i*4 +: 4] = 4'(i);
    run(v, 0, -1);
    run(v, 3, 5);
    for (int i = 0; i < NPIN; i++) v[i*4 +: 4] = 4'(i + 8);
    run(v, 1, 2);
    // All float pins with mixed device behaviour (R8)
    for (int i = 0; i < NPIN; i++) begin v[i*4 +: 4] = 4'd11; md[i] = 2'(i % 3); end
    run(v, 2, -1);
    // Expect pins against stuck levels (R7)
    for (int i = 0; i < NPIN; i++) begin v[i*4 +: 4] = (i < 4) ? 4'd9 : 4'd10; md[i] = 2'(1 + (i % 2)); end
    run(v, 0, 0);
    // All-pass vector (R10)
    for (int i = 0; i < NPIN; i++) begin v[i*4 +: 4] = 4'(i % 9); md[i] = 2'd0; end
    run(v, 1, -1);

    // Constrained random
    for (int n = 0; n < 40; n++) begin
      int len;
      len = int'($urandom % 5);
      for (int i = 0; i < NPIN; i++) begin
        v[i*4 +: 4] = ($urandom % 8 == 0) ? 4'($urandom % 16) : 4'($urandom % 12);
        md[i] = 2'($urandom % 3);
      end
      run(v, len, int'($urandom % (5 * (len + 1) + 4)));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule